// File: doc/BRIEF.md
# Message Object Transfer Controller

This block sits between a set of interface buffer registers and the message-object store of a CAN controller. Software first loads a command mask. The mask picks the direction of the transfer and which field groups take part. The groups are the acceptance mask, the arbitration word, the message control half-word, the first four data bytes and the last four data bytes. Software then writes an object number to the request register, which starts a transfer of fixed length between the interface registers and that object.

A transfer reads the whole stored object, merges in only the selected groups and writes the merged word back, so unselected groups never change. In the store-to-interface direction the same write-back can clear the object's interrupt-pending flag, its new-data flag, or both. In the interface-to-store direction it can set the transmit-request flag and clear the interrupt-pending flag. While a transfer runs, the block reports busy and ignores every register write.

Top module: `msg_xfer_ctrl`

## Requirements
- R1: After reset every register address (0 to 7) reads zero and `busy` is 0.
- R2: Address 0 holds the command mask in bits 7:0. Bits 31:8 read zero and are not stored. Bit 7 selects direction (1 = interface to object, 0 = object to interface). Bit 6 selects the mask group, bit 5 the arbitration group, bit 4 the control group, bit 1 data bytes 0-3 and bit 0 data bytes 4-7.
- R3: A write to address 1 starts a transfer on the object numbered by bits 4:0 of the write data. Numbers 1 to 31 address that object, and both 0 and 32 address object 32. Reading address 1 gives the busy flag in bit 15 and the last accepted bits 4:0 in bits 4:0.
- R4: `busy` rises on the clock edge that accepts the request and stays 1 for exactly 4 cycles. Any register write made while `busy` is 1, including a new request, is ignored.
- R5: With bit 7 = 1, each selected group is copied from its interface register (mask at address 2, arbitration at 3, control at 4, data bytes 0-3 at 5, data bytes 4-7 at 6) into the object. Every unselected group of the object keeps its previous contents.
- R6: With bit 7 = 1, command bit 2 sets the object's transmit-request flag (control bit 8), and command bit 3 clears its interrupt-pending flag (control bit 13). Both are applied after any control-group copy.
- R7: With bit 7 = 0, each selected group is loaded from the object into its interface register. Unselected interface registers keep their values, and the object's groups are left intact apart from the flags of R8.
- R8: With bit 7 = 0, command bit 3 clears the object's interrupt-pending flag (control bit 13) and command bit 2 clears its new-data flag (control bit 15). The interface control register receives the value from before the clearing.
- R9: The control register at address 4 stores only bits 15:0, and its bits 31:16 read zero. Address 7 always reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register chosen by `reg_addr` |
| busy | output | 1 | High while a transfer is running |

## Verification
The assertions take for granted that a request is issued by a single-cycle write to address 1 while the block is idle. They also assume that address 0 is read only through the combinational read port. The stimulus raises `reg_we` for one cycle per access and waits out each transfer before starting the next. It still drives one random write into the busy window of every transfer, so the ignore rule is exercised without breaking the assumptions. Every object is first filled through an all-groups write. Later random partial transfers therefore always merge against known stored contents.

// File: rtl/msg_xfer_pkg.sv
package msg_xfer_pkg;
    localparam int WORD_W = 32;
    localparam int CTL_W  = 16;
    localparam int CMD_W  = 8;
    localparam int ADDR_W = 3;

    // command mask bit positions
    localparam int CM_DIR   = 7;
    localparam int CM_MSK   = 6;
    localparam int CM_ARB   = 5;
    localparam int CM_CTL   = 4;
    localparam int CM_CLRIP = 3;
    localparam int CM_FLAG  = 2;
    localparam int CM_DA    = 1;
    localparam int CM_DB    = 0;

    // control half-word flag positions
    localparam int CTL_TXRQ   = 8;
    localparam int CTL_INTPND = 13;
    localparam int CTL_NEWDAT = 15;

    // register addresses
    localparam logic [ADDR_W-1:0] ADR_CMSK = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_REQ  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_MSK  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_ARB  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CTL  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_DA   = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_DB   = 3'd6;

    localparam int BUSY_BIT = 15;

    typedef struct packed {
        logic [WORD_W-1:0] msk;
        logic [WORD_W-1:0] arb;
        logic [CTL_W-1:0]  ctl;
        logic [WORD_W-1:0] da;
        logic [WORD_W-1:0] db;
    } obj_word_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_MERGE, ST_WRITE, ST_DONE
    } xfer_st_e;
endpackage

// File: rtl/msg_obj_ram.sv
module msg_obj_ram
    import msg_xfer_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            re,
    input  logic [AW-1:0]   raddr,
    output obj_word_t       rdata,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  obj_word_t       wdata
);
    obj_word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/msg_xfer_merge.sv
module msg_xfer_merge
    import msg_xfer_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  obj_word_t        ram_old,
    input  obj_word_t        if_old,
    output obj_word_t        ram_new,
    output obj_word_t        if_new
);
    always_comb begin
        ram_new = ram_old;
        if_new  = if_old;
        if (cmd[CM_DIR]) begin
            // interface registers into the object, per group
            if (cmd[CM_MSK]) ram_new.msk = if_old.msk;
            if (cmd[CM_ARB]) ram_new.arb = if_old.arb;
            if (cmd[CM_CTL]) ram_new.ctl = if_old.ctl;
            if (cmd[CM_DA])  ram_new.da  = if_old.da;
            if (cmd[CM_DB])  ram_new.db  = if_old.db;
            if (cmd[CM_FLAG])  ram_new.ctl[CTL_TXRQ]   = 1'b1;
            if (cmd[CM_CLRIP]) ram_new.ctl[CTL_INTPND] = 1'b0;
        end else begin
            // object into the interface registers; flags cleared in store only
            if (cmd[CM_MSK]) if_new.msk = ram_old.msk;
            if (cmd[CM_ARB]) if_new.arb = ram_old.arb;
            if (cmd[CM_CTL]) if_new.ctl = ram_old.ctl;
            if (cmd[CM_DA])  if_new.da  = ram_old.da;
            if (cmd[CM_DB])  if_new.db  = ram_old.db;
            if (cmd[CM_CLRIP]) ram_new.ctl[CTL_INTPND] = 1'b0;
            if (cmd[CM_FLAG])  ram_new.ctl[CTL_NEWDAT] = 1'b0;
        end
    end
endmodule

// File: rtl/msg_xfer_ctrl.sv
module msg_xfer_ctrl
    import msg_xfer_pkg::*;
#(
    parameter int NUM_OBJ = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                busy
);
    localparam int IDX_W = $clog2(NUM_OBJ);

    typedef struct packed {
        xfer_st_e          st;
        logic [CMD_W-1:0]  cmsk;
        logic [IDX_W-1:0]  num;
        obj_word_t         ifr;
        obj_word_t         wb;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    obj_word_t        ram_rdata;
    obj_word_t        ram_new;
    obj_word_t        if_new;
    logic [IDX_W-1:0] obj_idx;
    logic             ram_re;
    logic             ram_we;
    logic [CMD_W-1:0] cmsk_mon;

    // object number n lives at index n-1; number 0 wraps to the last object
    assign obj_idx  = st_q.num - IDX_W'(1);
    assign ram_re   = (st_q.st == ST_FETCH);
    assign ram_we   = (st_q.st == ST_WRITE);
    assign busy     = (st_q.st != ST_IDLE);
    assign cmsk_mon = st_q.cmsk;

    msg_obj_ram #(.DEPTH(NUM_OBJ)) u_ram (
        .clk   (clk),
        .re    (ram_re),
        .raddr (obj_idx),
        .rdata (ram_rdata),
        .we    (ram_we),
        .waddr (obj_idx),
        .wdata (st_q.wb)
    );

    msg_xfer_merge u_merge (
        .cmd     (st_q.cmsk),
        .ram_old (ram_rdata),
        .if_old  (st_q.ifr),
        .ram_new (ram_new),
        .if_new  (if_new)
    );

    always_comb begin
        st_d = st_q;
        if (reg_we && !busy) begin
            unique case (reg_addr)
                ADR_CMSK: st_d.cmsk    = reg_wdata[CMD_W-1:0];
                ADR_REQ: begin
                    st_d.num = reg_wdata[IDX_W-1:0];
                    st_d.st  = ST_FETCH;
                end
                ADR_MSK:  st_d.ifr.msk = reg_wdata;
                ADR_ARB:  st_d.ifr.arb = reg_wdata;
                ADR_CTL:  st_d.ifr.ctl = reg_wdata[CTL_W-1:0];
                ADR_DA:   st_d.ifr.da  = reg_wdata;
                ADR_DB:   st_d.ifr.db  = reg_wdata;
                default: ;
            endcase
        end
        unique case (st_q.st)
            ST_FETCH: st_d.st = ST_MERGE;
            ST_MERGE: begin
                st_d.wb  = ram_new;
                st_d.ifr = if_new;
                st_d.st  = ST_WRITE;
            end
            ST_WRITE: st_d.st = ST_DONE;
            ST_DONE:  st_d.st = ST_IDLE;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: ST_IDLE, default: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_CMSK: reg_rdata[CMD_W-1:0] = st_q.cmsk;
            ADR_REQ: begin
                reg_rdata[BUSY_BIT]  = busy;
                reg_rdata[IDX_W-1:0] = st_q.num;
            end
            ADR_MSK: reg_rdata = st_q.ifr.msk;
            ADR_ARB: reg_rdata = st_q.ifr.arb;
            ADR_CTL: reg_rdata[CTL_W-1:0] = st_q.ifr.ctl;
            ADR_DA:  reg_rdata = st_q.ifr.da;
            ADR_DB:  reg_rdata = st_q.ifr.db;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/msg_xfer_chk.sv
module msg_xfer_chk
    import msg_xfer_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [WORD_W-1:0]  reg_rdata,
    input logic               busy,
    input logic [CMD_W-1:0]   cmsk_q,
    input logic               ram_we
);
    assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 busy ##1 busy ##1 !busy);

    assert_start_on_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(reg_we && reg_addr == ADR_REQ)) |=> !busy);

    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmsk_q));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_CMSK) |-> (reg_rdata[WORD_W-1:CMD_W] == '0));

    assert_writeback_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (busy && $past(busy) && $past(busy, 2)));
endmodule

bind msg_xfer_ctrl msg_xfer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .cmsk_q    (cmsk_mon),
    .ram_we    (ram_we)
);

// File: tb/msg_xfer_ctrl_tb.sv
module msg_xfer_ctrl_tb;
    import msg_xfer_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    obj_word_t   m_ram [32];
    obj_word_t   m_if;
    logic [7:0]  m_cm;
    logic [4:0]  m_num;

    always #2 clk = ~clk;  // 250 MHz

    msg_xfer_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    // expected effect of one transfer, from R5 to R8
    function automatic void model_xfer();
        int idx;
        obj_word_t r;
        idx = (int'(m_num) + 31) % 32;
        r = m_ram[idx];
        if (m_cm[7]) begin
            if (m_cm[6]) r.msk = m_if.msk;
            if (m_cm[5]) r.arb = m_if.arb;
            if (m_cm[4]) r.ctl = m_if.ctl;
            if (m_cm[1]) r.da  = m_if.da;
            if (m_cm[0]) r.db  = m_if.db;
            if (m_cm[2]) r.ctl[8]  = 1'b1;
            if (m_cm[3]) r.ctl[13] = 1'b0;
        end else begin
            if (m_cm[6]) m_if.msk = r.msk;
            if (m_cm[5]) m_if.arb = r.arb;
            if (m_cm[4]) m_if.ctl = r.ctl;
            if (m_cm[1]) m_if.da  = r.da;
            if (m_cm[0]) m_if.db  = r.db;
            if (m_cm[3]) r.ctl[13] = 1'b0;
            if (m_cm[2]) r.ctl[15] = 1'b0;
        end
        m_ram[idx] = r;
    endfunction

    task automatic check_regs();
        rd_chk("R2 mask readback", ADR_CMSK, {24'b0, m_cm});
        rd_chk("R3 request readback", ADR_REQ, {27'b0, m_num});
        rd_chk("R5 R7 mask group", ADR_MSK, m_if.msk);
        rd_chk("R5 R7 arbitration group", ADR_ARB, m_if.arb);
        rd_chk("R6 R8 R9 control group", ADR_CTL, {16'b0, m_if.ctl});
        rd_chk("R5 R7 data bytes 0-3", ADR_DA, m_if.da);
        rd_chk("R5 R7 data bytes 4-7", ADR_DB, m_if.db);
    endtask

    task automatic set_if(input obj_word_t w);
        wr(ADR_MSK, w.msk); wr(ADR_ARB, w.arb); wr(ADR_CTL, {16'hDEAD, w.ctl});
        wr(ADR_DA, w.da);   wr(ADR_DB, w.db);
        m_if = w;
    endtask

    task automatic xfer(input logic [7:0] cm, input logic [31:0] num);
        wr(ADR_CMSK, {$urandom, cm} >> 0 & 32'hFFFF_FF00 | {24'b0, cm});
        m_cm = cm;
        wr(ADR_REQ, num);
        m_num = num[4:0];
        check("R4 busy after request", {31'b0, busy}, 32'd1);
        reg_we = 1'b1;  // ignored write inside the busy window
        reg_addr = 3'($urandom_range(0, 6));
        reg_wdata = $urandom;
        @(negedge clk);
        reg_we = 1'b0;
        check("R4 busy cycle 2", {31'b0, busy}, 32'd1);
        @(negedge clk);
        check("R4 busy cycle 3", {31'b0, busy}, 32'd1);
        @(negedge clk);
        check("R4 busy cycle 4", {31'b0, busy}, 32'd1);
        @(negedge clk);
        check("R4 busy low after 4 cycles", {31'b0, busy}, 32'd0);
        model_xfer();
        check_regs();
    endtask

    function automatic obj_word_t rnd_word();
        obj_word_t w;
        w.msk = $urandom; w.arb = $urandom; w.ctl = 16'($urandom);
        w.da = $urandom;  w.db = $urandom;
        return w;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        obj_word_t w;
        void'($urandom(32'd2024));
        m_if = '0; m_cm = '0; m_num = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 busy at reset", {31'b0, busy}, 32'd0);
        for (int a = 0; a < 8; a++) rd_chk("R1 reset value", 3'(a), 32'd0);

        // R2 reserved bits, R9 control width and empty address
        wr(ADR_CMSK, 32'hFFFF_FF5A);
        rd_chk("R2 reserved bits", ADR_CMSK, 32'h0000_005A);
        wr(ADR_CMSK, 32'd0);
        wr(ADR_CTL, 32'hABCD_1234);
        rd_chk("R9 control upper bits", ADR_CTL, 32'h0000_1234);
        m_if.ctl = 16'h1234;
        wr(ADR_7, 32'hFFFF_FFFF);
        rd_chk("R9 address 7", 3'd7, 32'd0);

        // fill every object with all groups (R5)
        for (int o = 1; o <= 32; o++) begin
            set_if(rnd_word());
            xfer(8'hF3, 32'(o));
        end

        // R3: number 0 and 32 alias object 32, upper request bits ignored
        w = rnd_word();
        set_if(w);
        xfer(8'hF3, 32'hFFFF_FFE0);
        set_if(rnd_word());
        xfer(8'h73, 32'd32);
        check("R3 object 0 aliases 32", m_if.da, w.da);

        // R6: transmit request set and interrupt pending cleared on write
        w = rnd_word(); w.ctl = 16'h2000;
        set_if(w);
        xfer(8'h9C, 32'd7);
        set_if(rnd_word());
        xfer(8'h10, 32'd7);
        check("R6 flags after write", {16'b0, m_if.ctl}, 32'h0000_0100);

        // R8: read clears pending and new data, interface gets old value
        w = rnd_word(); w.ctl = 16'hA0F5;
        set_if(w);
        xfer(8'h90, 32'd3);
        xfer(8'h1C, 32'd3);
        check("R8 pre-clear value", {16'b0, m_if.ctl}, 32'h0000_A0F5);
        xfer(8'h10, 32'd3);
        check("R8 flags cleared", {16'b0, m_if.ctl}, 32'h0000_00F5);

        // random mix covering R5 R7 partial groups
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 1) == 1) set_if(rnd_word());
            xfer(8'($urandom), 32'($urandom_range(0, 32)));
        end
        finish_run();
    end

    localparam logic [2:0] ADR_7 = 3'd7;
endmodule